// File: doc/BRIEF.md
# SDRAM Burst Read/Write Data Path with Programmable CAS Latency

This block models the device side of a single-bank SDR SDRAM data path. It samples the active-low chip-select, row-strobe, column-strobe and write-enable pins each clock, decodes them into mode-load, row-activate, read, write and idle commands, and serves reads and writes from a small internal array. A row register is loaded by row-activate. Each read or write takes its column from the address bus.

A mode register holds four settings: the burst length, the read latency (two or three clocks), an operating-mode field that must be zero, and a flag that limits writes to one location. Read data passes through a latency pipeline. A separate output enable for the shared data bus rises one cycle before the first word and falls one cycle after the last word appears. A memory controller model or a test harness uses the block as the memory on the far side of an SDRAM bus.

Top module: `sdram_rd_path`

## Requirements
- R1: Commands are decoded from {cs_ni, ras_ni, cas_ni, we_ni}. The mode load is 0000, row activate is 0011, read is 0101 and write is 0100. Any other combination, including every pattern with cs_ni high, is an idle cycle with no effect.
- R2: A mode load at edge n copies addr_i into the mode register, and commands from edge n+1 on use the new settings. Bits [2:0] select the burst length: 000=1, 001=2, 010=4, 011=8, and any other code gives 1. Bits [6:4] select the latency: 010=2, 011=3. Bits [8:7] select the operating mode. Bit 9 selects single-location writes. After reset the burst length is 1, the latency is 2, writes burst, and mode_err_o is 0.
- R3: For a read registered at edge n with latency L, dq_o carries burst word k from edge n+L+k.
- R4: dq_oe_o rises at edge n+L-1 and stays high until edge n+L+BL, so it falls one cycle after the last word has been placed on dq_o.
- R5: Burst word k goes to or comes from column (c & ~(BL-1)) | ((c+k) & (BL-1)), where c is the start column. The order is sequential and wraps inside the block of BL columns that contains c.
- R6: When bit 9 is 0, a write at edge n stores the dq_i value present at each edge n..n+BL-1 into burst word 0..BL-1.
- R7: When bit 9 is 1, a write stores only the word at edge n. Reads still use the full programmed burst length.
- R8: A mode load with bits [8:7] not 00, or with a latency code other than 010 or 011, sets mode_err_o. While the flag is set, reads and writes are ignored: no output, no change to memory, no truncation. A valid mode load clears the flag.
- R9: Idle and deselected cycles let a burst continue. A new read or write stops the words of the current burst that have not yet been issued. Words already issued still reach dq_o.
- R10: Row activate latches addr_i[ROW_W-1:0]. Accesses use array index row*2^COL_W + column.
- R11: dq_o is all zero whenever no read word is being presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | AW | Address bus: mode value, row or column |
| dq_i | input | DW | Write data |
| dq_o | output | DW | Read data |
| dq_oe_o | output | 1 | Output enable for the shared data bus |
| mode_err_o | output | 1 | A reserved mode was loaded; accesses are blocked |

## Verification
The assertions check these every cycle:
- the output enable is high one cycle before each first word and for as long as a word is presented;
- the data bus is zero when the enable is low;
- a block with a single-location write or a read stops a write burst on the next cycle;
- a write stops the issue of read words;
- read addresses stay inside their aligned block;
- a read never starts while the mode error is set.

Only the bench scenarios can show the exact edge of the first word for each latency, wrapped column order against stored contents, truncation points, and that ignored writes leave memory untouched. The bench shows these by comparing every cycle against a behavioural memory and a schedule of expected output.

// File: rtl/sdram_rd_pkg.sv
`timescale 1ns/1ps
package sdram_rd_pkg;

  typedef enum logic [2:0] {CMD_NOP, CMD_LMR, CMD_ACT, CMD_RD, CMD_WR} cmd_e;

  typedef struct packed {
    logic [3:0] blen;      // words per burst, 1/2/4/8
    logic       cl3;       // 1: latency 3, 0: latency 2
    logic       wr_single; // writes touch one location only
  } mode_t;

  function automatic cmd_e decode_cmd(input logic [3:0] pins);
    case (pins)
      4'b0000: return CMD_LMR;
      4'b0011: return CMD_ACT;
      4'b0101: return CMD_RD;
      4'b0100: return CMD_WR;
      default: return CMD_NOP;
    endcase
  endfunction

  function automatic logic [3:0] blen_of(input logic [2:0] code);
    case (code)
      3'b001:  return 4'd2;
      3'b010:  return 4'd4;
      3'b011:  return 4'd8;
      default: return 4'd1;
    endcase
  endfunction

endpackage

// File: rtl/sdram_cmd_mode.sv
`timescale 1ns/1ps
module sdram_cmd_mode
  import sdram_rd_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          ras_ni,
  input  logic          cas_ni,
  input  logic          we_ni,
  input  logic [AW-1:0] addr_i,
  output cmd_e          cmd_o,
  output mode_t         mode_o,
  output logic          err_o
);

  logic cl_ok;
  logic unused_bits;

  assign unused_bits = ^{addr_i[AW-1:10], addr_i[3]};
  assign cl_ok = (addr_i[6:4] == 3'b010) || (addr_i[6:4] == 3'b011);

  always_comb cmd_o = decode_cmd({cs_ni, ras_ni, cas_ni, we_ni});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= '{blen: 4'd1, cl3: 1'b0, wr_single: 1'b0};
      err_o  <= 1'b0;
    end else if (cmd_o == CMD_LMR) begin
      mode_o.blen      <= blen_of(addr_i[2:0]);
      mode_o.cl3       <= (addr_i[6:4] == 3'b011);
      mode_o.wr_single <= addr_i[9];
      err_o            <= !cl_ok || (addr_i[8:7] != 2'b00);
    end
  end

  a_r8_flag_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_LMR && addr_i[8:7] != 2'b00) |=> err_o);

  a_r2_blen_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o.blen != 4'd0) && $onehot0(mode_o.blen));

endmodule

// File: rtl/sdram_burst_ctl.sv
`timescale 1ns/1ps
module sdram_burst_ctl #(
  parameter int COL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_go_i,
  input  logic             wr_go_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [3:0]       blen_i,
  input  logic             single_i,
  output logic             rd_issue_o,
  output logic [COL_W-1:0] rd_col_o,
  output logic             we_o,
  output logic [COL_W-1:0] wcol_o
);

  function automatic logic [COL_W-1:0] step(input logic [COL_W-1:0] c,
                                            input logic [COL_W-1:0] m);
    return (c & ~m) | ((c + 1'b1) & m);
  endfunction

  logic [COL_W-1:0] mask, rd_mask, wr_mask, rd_col, wr_col;
  logic [3:0]       rd_left, wr_left, wlen;
  logic             rd_act, wr_act;

  assign mask = COL_W'(blen_i - 4'd1);
  assign wlen = single_i ? 4'd1 : blen_i;

  // read issue: one column per cycle while active
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_act  <= 1'b0;
      rd_left <= '0;
      rd_col  <= '0;
      rd_mask <= '0;
    end else if (rd_go_i) begin
      rd_act  <= 1'b1;
      rd_left <= blen_i;
      rd_col  <= col_i;
      rd_mask <= mask;
    end else if (wr_go_i) begin
      rd_act  <= 1'b0;
    end else if (rd_act) begin
      if (rd_left == 4'd1) rd_act <= 1'b0;
      else begin
        rd_left <= rd_left - 4'd1;
        rd_col  <= step(rd_col, rd_mask);
      end
    end
  end

  // write burst: word 0 with the command, the rest on following edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_act  <= 1'b0;
      wr_left <= '0;
      wr_col  <= '0;
      wr_mask <= '0;
    end else if (wr_go_i) begin
      wr_act  <= (wlen > 4'd1);
      wr_left <= wlen - 4'd1;
      wr_col  <= step(col_i, mask);
      wr_mask <= mask;
    end else if (rd_go_i) begin
      wr_act  <= 1'b0;
    end else if (wr_act) begin
      if (wr_left == 4'd1) wr_act <= 1'b0;
      else begin
        wr_left <= wr_left - 4'd1;
        wr_col  <= step(wr_col, wr_mask);
      end
    end
  end

  assign rd_issue_o = rd_act;
  assign rd_col_o   = rd_col;
  assign we_o       = wr_go_i || (wr_act && !rd_go_i);
  assign wcol_o     = wr_go_i ? col_i : wr_col;

  a_r7_single_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_go_i && single_i) |=> !wr_act);

  a_r9_read_stops_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_go_i |=> !wr_act);

  a_r9_write_stops_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_go_i && !rd_go_i) |=> !rd_act);

  a_r5_wrap_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_act && $past(rd_act && !rd_go_i && !wr_go_i))
      |-> ((rd_col & ~rd_mask) == ($past(rd_col) & ~rd_mask)));

endmodule

// File: rtl/sdram_lat_pipe.sv
`timescale 1ns/1ps
module sdram_lat_pipe #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_i,
  input  logic [DW-1:0] data_i,
  input  logic          cl3_i,
  output logic [DW-1:0] dq_o,
  output logic          oe_o
);

  localparam int STAGES = 3;  // longest latency

  logic [STAGES:1] vld;
  logic [DW-1:0]   dat [STAGES:1];
  logic            vt;
  logic [DW-1:0]   dt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld <= '0;
    else         vld <= {vld[STAGES-1:1], issue_i};
  end

  generate
    for (genvar s = 1; s <= STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     dat[s] <= '0;
        else if (s == 1) dat[s] <= data_i;
        else             dat[s] <= dat[(s > 1) ? s-1 : 1];
      end
    end
  endgenerate

  // tap at stage L, enable one stage earlier
  assign vt   = cl3_i ? vld[3] : vld[2];
  assign dt   = cl3_i ? dat[3] : dat[2];
  assign oe_o = cl3_i ? (vld[2] | vld[3]) : (vld[1] | vld[2]);
  assign dq_o = vt ? dt : '0;

  a_r4_oe_leads_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vt) |-> $past(oe_o));

  a_r4_oe_covers_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vt |-> oe_o);

  a_r11_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> (dq_o == '0));

endmodule

// File: rtl/sdram_rd_path.sv
`timescale 1ns/1ps
module sdram_rd_path
  import sdram_rd_pkg::*;
#(
  parameter int DW    = 16,
  parameter int AW    = 12,
  parameter int ROW_W = 2,
  parameter int COL_W = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          ras_ni,
  input  logic          cas_ni,
  input  logic          we_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  output logic          mode_err_o
);

  localparam int MEM_AW = ROW_W + COL_W;
  localparam int DEPTH  = 1 << MEM_AW;

  cmd_e             cmd;
  mode_t            mode;
  logic             mode_err, rd_go, wr_go, rd_issue, we;
  logic [COL_W-1:0] rd_col, wcol;
  logic [ROW_W-1:0] row_q;
  logic [DW-1:0]    mem [DEPTH];

  sdram_cmd_mode #(.AW(AW)) u_cmd (
    .clk_i, .rst_ni, .cs_ni, .ras_ni, .cas_ni, .we_ni, .addr_i,
    .cmd_o(cmd), .mode_o(mode), .err_o(mode_err)
  );

  assign rd_go = (cmd == CMD_RD) && !mode_err;
  assign wr_go = (cmd == CMD_WR) && !mode_err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               row_q <= '0;
    else if (cmd == CMD_ACT)   row_q <= addr_i[ROW_W-1:0];
  end

  sdram_burst_ctl #(.COL_W(COL_W)) u_burst (
    .clk_i, .rst_ni, .rd_go_i(rd_go), .wr_go_i(wr_go),
    .col_i(addr_i[COL_W-1:0]), .blen_i(mode.blen), .single_i(mode.wr_single),
    .rd_issue_o(rd_issue), .rd_col_o(rd_col), .we_o(we), .wcol_o(wcol)
  );

  always_ff @(posedge clk_i) begin
    if (we) mem[{row_q, wcol}] <= dq_i;
  end

  sdram_lat_pipe #(.DW(DW)) u_pipe (
    .clk_i, .rst_ni, .issue_i(rd_issue), .data_i(mem[{row_q, rd_col}]),
    .cl3_i(mode.cl3), .dq_o, .oe_o(dq_oe_o)
  );

  assign mode_err_o = mode_err;

  a_r8_no_read_in_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_issue) |-> !$past(mode_err));

endmodule

// File: tb/tb_sdram_rd_path.sv
`timescale 1ns/1ps
module tb_sdram_rd_path;
  localparam int DW = 16, AW = 12, ROW_W = 2, COL_W = 4, NT = 8192;
  localparam logic [3:0] P_NOP = 4'b0111, P_LMR = 4'b0000, P_ACT = 4'b0011,
                         P_RD  = 4'b0101, P_WR  = 4'b0100, P_DES = 4'b1000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_i = '0, dq_o;
  logic dq_oe, mode_err;

  sdram_rd_path #(.DW(DW), .AW(AW), .ROW_W(ROW_W), .COL_W(COL_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .we_ni(we_n), .addr_i(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe_o(dq_oe),
    .mode_err_o(mode_err)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R2";
  bit done = 0;

  // reference model state
  bit            exp_v [NT];
  logic [DW-1:0] exp_d [NT];
  bit            exp_e [NT];
  logic [DW-1:0] mmem [64];
  int m_bl = 1, m_cl = 2, m_row = 0;
  bit m_err = 0, m_wbm = 0;
  int last_n = -100, last_bl = 0, last_cl = 2;

  function automatic int wrapc(int col, int k, int bl);
    return (col & ~(bl - 1)) | ((col + k) & (bl - 1));
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h cyc=%0d", req, what, act, exp, cyc);
    end
  endtask

  // every-cycle comparison: R3 R4 R11 data/enable schedule, R8 flag
  always @(negedge clk) begin
    if (rst_n && !done && cyc < NT - 1) begin
      check(cur_req, "dq_o", 32'(dq_o), exp_v[cyc] ? 32'(exp_d[cyc]) : 32'd0);
      check(cur_req, "dq_oe_o", 32'(dq_oe), 32'(exp_v[cyc] | exp_v[cyc+1]));
      check(cur_req, "mode_err_o", 32'(mode_err), 32'(exp_e[cyc]));
    end
  end

  task automatic drive(logic [3:0] pins, logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = pins;
    addr = a;
    dq_i = d;
  endtask

  task automatic nop(int n);
    for (int i = 0; i < n; i++) drive(P_NOP, '0, '0);
  endtask

  task automatic des(int n);
    for (int i = 0; i < n; i++) drive(P_DES, '0, '0);
  endtask

  task automatic lmr(int blc, int clc, int op, int wbm);
    int n;
    drive(P_LMR, AW'((wbm << 9) | (op << 7) | (clc << 4) | blc), '0);
    n = cyc + 1;
    m_bl  = (blc == 1) ? 2 : (blc == 2) ? 4 : (blc == 3) ? 8 : 1;
    m_cl  = (clc == 3) ? 3 : 2;
    m_wbm = wbm[0];
    m_err = (op != 0) || !(clc == 2 || clc == 3);
    for (int t = n; t < NT; t++) exp_e[t] = m_err;
  endtask

  task automatic act(int row);
    drive(P_ACT, AW'(row), '0);
    m_row = row;
  endtask

  task automatic cancel_rd(int n);
    for (int k = n - last_n; k < last_bl; k++) exp_v[last_n + last_cl + k] = 0;
  endtask

  task automatic rd(int col);
    int n;
    drive(P_RD, AW'(col), '0);
    n = cyc + 1;
    if (!m_err) begin
      cancel_rd(n);
      for (int k = 0; k < m_bl; k++) begin
        exp_v[n + m_cl + k] = 1;
        exp_d[n + m_cl + k] = mmem[m_row * 16 + wrapc(col, k, m_bl)];
      end
      last_n = n; last_bl = m_bl; last_cl = m_cl;
    end
  endtask

  task automatic wr(int col, logic [DW-1:0] base, int nops);
    int n, wl;
    drive(P_WR, AW'(col), base);
    n = cyc + 1;
    wl = m_wbm ? 1 : m_bl;
    if (!m_err) cancel_rd(n);
    for (int k = 0; k <= nops; k++) begin
      if (k > 0) drive(P_NOP, '0, base + DW'(k));
      if (!m_err && k < wl) mmem[m_row * 16 + wrapc(col, k, wl)] = base + DW'(k);
    end
  endtask

  initial begin
    for (int t = 0; t < NT; t++) begin exp_v[t] = 0; exp_d[t] = '0; exp_e[t] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", "reset dq_oe_o", 32'(dq_oe), 32'd0);
    check("R2", "reset dq_o", 32'(dq_o), 32'd0);
    check("R2", "reset mode_err_o", 32'(mode_err), 32'd0);

    // fill rows 0 and 1 with BL8 write bursts (R6, R10)
    cur_req = "R6";
    lmr(3, 2, 0, 0);
    act(0); wr(0, 16'h0A00, 7); wr(8, 16'h0A08, 7);
    act(1); wr(0, 16'h1B00, 7); wr(8, 16'h1B08, 7);
    nop(4);

    // R3 R4: BL1 latency 2; deselect with mode-load pins does nothing (R1)
    cur_req = "R3";
    lmr(0, 2, 0, 0);
    wr(3, 16'h1111, 0); nop(2);
    drive(4'b1000, AW'(12'h3FF), '0);
    rd(3); nop(6);

    // R5 R6: BL4 wrapped write and read
    cur_req = "R5";
    lmr(2, 2, 0, 0);
    wr(5, 16'h2000, 3); nop(1);
    rd(4); nop(3); rd(6); nop(8);

    // R3 R4: latency 3, BL8 wrapped and BL2
    cur_req = "R4";
    lmr(3, 3, 0, 0);
    wr(2, 16'h3000, 7);
    rd(6); nop(14);
    lmr(1, 3, 0, 0);
    rd(1); nop(2); rd(14); nop(8);

    // R7: single-location writes, reads still burst
    cur_req = "R7";
    lmr(2, 2, 0, 1);
    wr(8, 16'h4000, 3); nop(1);
    rd(8); nop(8);

    // R9: truncation and deselect continuation
    cur_req = "R9";
    lmr(3, 2, 0, 0);
    rd(0); nop(2); rd(8); nop(12);
    rd(0); des(3); nop(12);
    rd(0); nop(3); wr(4, 16'h5000, 1); rd(0); nop(12);
    wr(8, 16'h5100, 2); rd(8); nop(12);

    // R8: reserved op mode and reserved latency block accesses
    cur_req = "R8";
    lmr(3, 2, 1, 0); nop(1);
    rd(0); nop(6);
    wr(0, 16'h6666, 7); nop(2);
    lmr(3, 1, 0, 0); nop(1);
    rd(0); nop(6);
    lmr(3, 2, 0, 0); nop(1);
    rd(0); nop(12);

    // R2: reserved burst code gives length 1
    cur_req = "R2";
    lmr(4, 3, 0, 0);
    rd(5); nop(8);

    // R10: row 0 contents differ from row 1
    cur_req = "R10";
    act(0); lmr(2, 2, 0, 0);
    rd(3); nop(8);
    act(1); rd(3); nop(8);

    // R1: undefined pin combination is idle, R11 bus stays zero
    cur_req = "R11";
    drive(4'b0110, '0, '0); drive(4'b0001, '0, 16'hFFFF); nop(6);
    cur_req = "R1";
    rd(9); nop(8);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule